// File: doc/BRIEF.md
# Process-Tagged Address Translation Buffer

This block turns virtual addresses into physical addresses for a small processor. It holds four translations for 4 KB pages. Each translation carries a virtual page number, the owning process number and a permission flag for stores. A lookup is purely combinational. The caller presents an address together with a store flag and a user-mode flag, and reads back the translated address and a hit flag in the same cycle. The current process number is held in a register inside the block.

Translation applies only while the processor runs in user mode with a nonzero process number. In every other case the address passes through untouched. When a translated lookup finds no usable entry, the untranslated address is still returned. One clock later the block emits a single-cycle fault pulse and records the faulting page, so that software can refill an entry. Software reaches the process register, the fault page register and the four entries through a word-wide configuration window.

The lookup port takes a single valid qualifier and applies no back-pressure. The block accepts a request in every cycle in which it is valid. A request with valid low produces no hit and no fault, and it changes no state. The configuration window is always ready, and its read data is combinational from the address.

Top module: `ptag_tlb`

## Requirements
- R1: While the process register holds 0, `lk_paddr` equals `lk_vaddr`, `lk_hit` stays 0 and no fault is raised.
- R2: While `lk_user` is 0, `lk_paddr` equals `lk_vaddr`, `lk_hit` stays 0 and no fault is raised, whatever the process number.
- R3: An entry is usable when bit 0 of its tag word is ignored and the tag word then equals the virtual address with bits 11:0 cleared, ORed with the process number shifted left by one. On a valid translated lookup that finds a usable entry, `lk_hit` is 1 and `lk_paddr` is that entry's page word ORed with `lk_vaddr[11:0]`.
- R4: An entry whose tag names a different process number is never usable.
- R5: Bit 0 of the tag word marks the page as writable. A store (`lk_write`=1) can use only an entry with that bit set. A load ignores the bit.
- R6: A valid translated lookup with no usable entry returns `lk_paddr` = `lk_vaddr` with `lk_hit` 0. On the next clock edge, `fault_o` pulses to 1 and `fault_page_o` becomes `lk_vaddr` with bits 11:0 cleared.
- R7: When several entries are usable, the entry with the lowest index supplies the translation.
- R8: Window layout, as byte offsets on `cfg_addr`. The process register sits at 0x80, holds PID_W bits and reads back zero-extended. The fault page sits at 0x90. Entry i has its tag word at 0xA0+8*i and its page word at 0xA4+8*i. Every one of these reads back through `cfg_rdata`.
- R9: A write to offset 0x90 or to any unmapped offset changes no state. An unmapped offset reads 0.
- R10: After reset, the process register, the fault page and every entry word read 0, and `fault_o` is 0.
- R11: While `lk_valid` is 0, `lk_hit` is 0, no fault pulse follows and `fault_page_o` keeps its value.
- R12: `fault_o` is 1 only in the cycle that follows a missing request. `fault_page_o` holds its value until the next miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request qualifier |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Request is a store |
| lk_user | input | 1 | Processor is in user mode |
| lk_paddr | output | 32 | Translated or passed-through address |
| lk_hit | output | 1 | A usable entry supplied the translation |
| fault_o | output | 1 | One-cycle pulse after a missing lookup |
| fault_page_o | output | 32 | Page of the most recent missing lookup |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |

## Verification
The main sweep loads four entries. Two of them share one page for process 1, one is read-only and the other writable, so the sweep can tell apart a permission miss, a priority choice and a fall-through to a higher entry. A third entry maps the same page as entry 0 for process 2, so a match on page alone does not count as a hit. The sweep covers process numbers 0 to 3, both mode settings, loads and stores, eight page numbers, and offsets of 0x000, 0xABC and 0xFFF. This separates the bypass cases, true hits and misses, and shows that the offset reaches the output intact. Directed steps then check the window layout, writes that must have no effect, and idle requests.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;
  typedef struct packed {
    word_t tag;
    word_t page;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_cfg_regs.sv
`timescale 1ns/1ps
module tlb_cfg_regs
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int PID_W   = 8,
  parameter int CFG_AW  = 8,
  parameter int PID_OFF = 'h80,
  parameter int FLT_OFF = 'h90,
  parameter int TBL_OFF = 'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  word_t             cfg_wdata,
  output word_t             cfg_rdata,
  input  word_t             fault_page_i,
  output logic [PID_W-1:0]  pid_o,
  output tlb_ent_t          ent_o [ENTRIES]
);
  localparam logic [CFG_AW-1:0] A_PID = CFG_AW'(PID_OFF);
  localparam logic [CFG_AW-1:0] A_FLT = CFG_AW'(FLT_OFF);

  logic  [ENTRIES-1:0] rd_hit;
  word_t               rd_val [ENTRIES];

  // process number register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pid_o <= '0;
    else if (cfg_we && cfg_addr == A_PID) pid_o <= cfg_wdata[PID_W-1:0];
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam logic [CFG_AW-1:0] A_TAG = CFG_AW'(TBL_OFF + 8*i);
    localparam logic [CFG_AW-1:0] A_PG  = CFG_AW'(TBL_OFF + 8*i + 4);
    word_t tag_q, page_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q  <= '0;
        page_q <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == A_TAG) tag_q  <= cfg_wdata;
        if (cfg_addr == A_PG)  page_q <= cfg_wdata;
      end
    end

    assign ent_o[i]  = '{tag: tag_q, page: page_q};
    assign rd_hit[i] = (cfg_addr == A_TAG) || (cfg_addr == A_PG);
    assign rd_val[i] = (cfg_addr == A_TAG) ? tag_q : page_q;
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == A_PID) cfg_rdata = word_t'(pid_o);
    if (cfg_addr == A_FLT) cfg_rdata = fault_page_i;
    for (int i = 0; i < ENTRIES; i++)
      if (rd_hit[i]) cfg_rdata = rd_val[i];
  end
endmodule

// File: rtl/tlb_lookup.sv
`timescale 1ns/1ps
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int PAGE_BITS = 12,
  parameter int PID_W     = 8
) (
  input  word_t              vaddr,
  input  logic               is_write,
  input  logic [PID_W-1:0]   pid,
  input  tlb_ent_t           ent [ENTRIES],
  output logic [ENTRIES-1:0] match_vec,
  output logic               any_match,
  output word_t              xlat_addr
);
  localparam word_t OFF_MASK = word_t'((64'd1 << PAGE_BITS) - 64'd1);

  word_t probe;
  assign probe = (vaddr & ~OFF_MASK) | (word_t'(pid) << 1);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match_vec[i] = ((ent[i].tag & ~word_t'(1)) == probe) &&
                          (!is_write || ent[i].tag[0]);
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    any_match = 1'b0;
    xlat_addr = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        any_match = 1'b1;
        xlat_addr = ent[i].page | (vaddr & OFF_MASK);
      end
    end
  end
endmodule

// File: rtl/tlb_fault.sv
`timescale 1ns/1ps
module tlb_fault
  import tlb_pkg::*;
#(
  parameter int PAGE_BITS = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      miss_i,
  input  logic [WORD_W-1:PAGE_BITS] vpage_i,
  output logic                      fault_o,
  output word_t                     page_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_o <= 1'b0;
      page_o  <= '0;
    end else begin
      fault_o <= miss_i;
      if (miss_i) page_o <= {vpage_i, {PAGE_BITS{1'b0}}};
    end
  end
endmodule

// File: rtl/ptag_tlb.sv
`timescale 1ns/1ps
module ptag_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES   = 4,
  parameter int PAGE_BITS = 12,
  parameter int PID_W     = 8,
  parameter int CFG_AW    = 8,
  parameter int PID_OFF   = 'h80,
  parameter int FLT_OFF   = 'h90,
  parameter int TBL_OFF   = 'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [31:0]       lk_vaddr,
  input  logic              lk_write,
  input  logic              lk_user,
  output logic [31:0]       lk_paddr,
  output logic              lk_hit,
  output logic              fault_o,
  output logic [31:0]       fault_page_o,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata
);
  logic [PID_W-1:0]   cur_pid;
  tlb_ent_t           ents [ENTRIES];
  logic [ENTRIES-1:0] match_vec;
  logic               any_match;
  word_t              xlat_addr;
  logic               active;
  logic               miss;

  tlb_cfg_regs #(
    .ENTRIES(ENTRIES), .PID_W(PID_W), .CFG_AW(CFG_AW),
    .PID_OFF(PID_OFF), .FLT_OFF(FLT_OFF), .TBL_OFF(TBL_OFF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fault_page_i(fault_page_o), .pid_o(cur_pid), .ent_o(ents)
  );

  tlb_lookup #(
    .ENTRIES(ENTRIES), .PAGE_BITS(PAGE_BITS), .PID_W(PID_W)
  ) u_look (
    .vaddr(lk_vaddr), .is_write(lk_write), .pid(cur_pid), .ent(ents),
    .match_vec(match_vec), .any_match(any_match), .xlat_addr(xlat_addr)
  );

  // translation only for user mode with a nonzero process number
  assign active   = lk_valid && lk_user && (cur_pid != '0);
  assign lk_hit   = active && any_match;
  assign miss     = active && !any_match;
  assign lk_paddr = lk_hit ? xlat_addr : lk_vaddr;

  tlb_fault #(.PAGE_BITS(PAGE_BITS)) u_fault (
    .clk(clk), .rst_n(rst_n), .miss_i(miss),
    .vpage_i(lk_vaddr[WORD_W-1:PAGE_BITS]),
    .fault_o(fault_o), .page_o(fault_page_o)
  );
endmodule

// File: rtl/tlb_sva.sv
`timescale 1ns/1ps
module tlb_sva #(
  parameter int ENTRIES   = 4,
  parameter int PAGE_BITS = 12,
  parameter int PID_W     = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [31:0]        lk_vaddr,
  input logic               lk_user,
  input logic [31:0]        lk_paddr,
  input logic               lk_hit,
  input logic               fault_o,
  input logic [31:0]        fault_page_o,
  input logic [PID_W-1:0]   cur_pid,
  input logic [ENTRIES-1:0] match_vec
);
  logic xl;
  assign xl = lk_valid && lk_user && (cur_pid != '0);

  assert_bypass_pid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_pid == '0) |-> (lk_paddr == lk_vaddr) && !lk_hit);

  assert_bypass_kernel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_user |-> (lk_paddr == lk_vaddr) && !lk_hit);

  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((lk_paddr[PAGE_BITS-1:0] & lk_vaddr[PAGE_BITS-1:0]) == lk_vaddr[PAGE_BITS-1:0]));

  assert_hit_has_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (match_vec != '0));

  assert_miss_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xl && !lk_hit) |=> fault_o &&
      (fault_page_o[31:PAGE_BITS] == $past(lk_vaddr[31:PAGE_BITS])) &&
      (fault_page_o[PAGE_BITS-1:0] == '0));

  assert_miss_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xl && !lk_hit) |-> (lk_paddr == lk_vaddr));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !fault_o);

  assert_page_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_o |-> $stable(fault_page_o));
endmodule

bind ptag_tlb tlb_sva #(
  .ENTRIES(ENTRIES), .PAGE_BITS(PAGE_BITS), .PID_W(PID_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .lk_user(lk_user), .lk_paddr(lk_paddr), .lk_hit(lk_hit),
  .fault_o(fault_o), .fault_page_o(fault_page_o),
  .cur_pid(cur_pid), .match_vec(match_vec)
);

// File: tb/ptag_tlb_test.sv
`timescale 1ns/1ps
module ptag_tlb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        lk_user = 1'b0;
  logic [31:0] lk_paddr;
  logic        lk_hit;
  logic        fault_o;
  logic [31:0] fault_page_o;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] mtag [4];
  logic [31:0] mpg  [4];
  logic [31:0] exp_fpage = '0;

  always #2.5 clk = ~clk;

  ptag_tlb uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_user(lk_user), .lk_paddr(lk_paddr),
    .lk_hit(lk_hit), .fault_o(fault_o), .fault_page_o(fault_page_o),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    lk_valid  = 1'b0;
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic cfg_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  // expected result computed from the requirement text
  task automatic model(input logic [31:0] va, input logic wr, input logic usr,
                       input logic [7:0] pid, output logic [31:0] pa,
                       output logic h, output logic miss);
    logic [31:0] probe;
    pa = va; h = 1'b0; miss = 1'b0;
    if (pid != 0 && usr) begin
      probe = {va[31:12], 12'h000} + {23'd0, pid, 1'b0};
      for (int i = 3; i >= 0; i--) begin
        if ({mtag[i][31:1], 1'b0} == probe && (!wr || mtag[i][0])) begin
          h  = 1'b1;
          pa = mpg[i] | {20'd0, va[11:0]};
        end
      end
      miss = !h;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] epa;
    logic        eh, em;
    logic [31:0] offs [3];
    string       lab;
    offs[0] = 32'h000; offs[1] = 32'hABC; offs[2] = 32'hFFF;
    mtag[0] = 32'h0000_1003; mpg[0] = 32'h0008_0000;
    mtag[1] = 32'h0000_2002; mpg[1] = 32'h0009_0000;
    mtag[2] = 32'h0000_1004; mpg[2] = 32'h000A_0000;
    mtag[3] = 32'h0000_2003; mpg[3] = 32'h000B_0000;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset state
    check("R10 fault", {31'd0, fault_o}, 32'd0);
    cfg_check("R10 pid", 8'h80, 32'd0);
    cfg_check("R10 fpage", 8'h90, 32'd0);
    for (int i = 0; i < 4; i++) begin
      cfg_check("R10 tag", 8'hA0 + 8'(8*i), 32'd0);
      cfg_check("R10 page", 8'hA4 + 8'(8*i), 32'd0);
    end

    // R8: load entries and read back the layout
    for (int i = 0; i < 4; i++) begin
      cfg_write(8'hA0 + 8'(8*i), mtag[i]);
      cfg_write(8'hA4 + 8'(8*i), mpg[i]);
    end
    for (int i = 0; i < 4; i++) begin
      cfg_check("R8 tag", 8'hA0 + 8'(8*i), mtag[i]);
      cfg_check("R8 page", 8'hA4 + 8'(8*i), mpg[i]);
    end
    cfg_write(8'h80, 32'hFFFF_FF05);
    cfg_check("R8 pid width", 8'h80, 32'h0000_0005);

    // main sweep
    for (int p = 0; p < 4; p++) begin
      cfg_write(8'h80, 32'(p));
      for (int u = 0; u < 2; u++)
        for (int w = 0; w < 2; w++)
          for (int vp = 0; vp < 8; vp++)
            for (int o = 0; o < 3; o++) begin
              @(negedge clk);
              lk_valid = 1'b1;
              lk_user  = u[0];
              lk_write = w[0];
              lk_vaddr = (32'(vp) << 12) | offs[o] | (vp == 7 ? 32'hF000_0000 : 32'd0);
              model(lk_vaddr, lk_write, lk_user, 8'(p), epa, eh, em);
              if (p == 0)                lab = "R1";
              else if (u == 0)           lab = "R2";
              else if (em && (vp == 1 || vp == 2)) lab = "R4_R5";
              else if (em)               lab = "R6";
              else if (vp == 2)          lab = "R7";
              else                       lab = "R3";
              #1;
              check({lab, " paddr"}, lk_paddr, epa);
              check({lab, " hit"}, {31'd0, lk_hit}, {31'd0, eh});
              if (em) exp_fpage = {lk_vaddr[31:12], 12'h000};
              @(posedge clk);
              #1;
              check("R6_R12 fault", {31'd0, fault_o}, {31'd0, em});
              check("R6_R12 fpage", fault_page_o, exp_fpage);
            end
    end

    // R9: writes to the fault page and to unmapped offsets change nothing
    @(negedge clk);
    lk_valid = 1'b0;
    cfg_write(8'h90, 32'hDEAD_B000);
    cfg_check("R9 fpage ro", 8'h90, exp_fpage);
    cfg_write(8'h44, 32'h1234_5678);
    cfg_check("R9 unmapped read", 8'h44, 32'd0);
    cfg_check("R9 entries intact", 8'hA0, mtag[0]);
    cfg_check("R9 pid intact", 8'h80, 32'd3);

    // R11: idle requests produce no hit and no fault
    cfg_write(8'h80, 32'd1);
    @(negedge clk);
    lk_valid = 1'b0; lk_user = 1'b1; lk_write = 1'b0;
    lk_vaddr = 32'h0000_1234;
    #1;
    check("R11 hit idle", {31'd0, lk_hit}, 32'd0);
    lk_vaddr = 32'h0000_7000;
    @(posedge clk);
    #1;
    check("R11 fault idle", {31'd0, fault_o}, 32'd0);
    check("R11 fpage idle", fault_page_o, exp_fpage);

    // R12: a miss then a hit gives exactly one pulse
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = 32'h0000_5010;
    @(negedge clk);
    lk_vaddr = 32'h0000_1010;
    #1;
    check("R12 pulse", {31'd0, fault_o}, 32'd1);
    check("R3 hit after miss", lk_paddr, 32'h0008_0010);
    @(negedge clk);
    lk_valid = 1'b0;
    check("R12 pulse ends", {31'd0, fault_o}, 32'd0);
    check("R12 fpage held", fault_page_o, 32'h0000_5000);

    done = 1;
    summary();
  end
endmodule